// File: doc/BRIEF.md
# Power-Delivery PHY Timing Strobe Generator

This block produces every timing strobe that a single-wire bi-phase-mark physical layer needs, all from one kernel clock. The clock first goes through a power-of-two prescaler chosen by a 3-bit code. A programmable divide-by-(N+1) stage then turns the prescaled rate into a half-bit tick, which is about 600 kHz at typical settings.

Two counters are driven by the half-bit tick. The first is free running and emits a transition-window strobe every (N+1) half-bit ticks. The second is an inter-frame-gap timer. A start pulse restarts it, and it raises a done flag once the programmed number of half-bit ticks has passed.

Every strobe is a pulse one kernel clock wide, not a derived clock. Configuration must stay static while the enable is high. Dropping the enable returns every counter to zero.

Top module: `pd_phy_timing_gen`

## Requirements
- R1: With prescaler code c in 0..4, the prescaled rate is the kernel clock divided by 2^c.
- R2: Prescaler codes 5, 6 and 7 divide by 16.
- R3: With prescale ratio P and half-bit field H, `hbit_tick_o` is high for exactly one clock in every P*(H+1) enabled clocks. Counting the first enabled clock as cycle 0, the first pulse falls in cycle P*(H+1)-1.
- R4: With window field T, `twin_tick_o` pulses together with every (T+1)-th half-bit tick, starting with the (T+1)-th tick after enable.
- R5: After `ifg_start_i` is sampled high in cycle s, `ifg_done_o` rises in the cycle after the (G+1)-th half-bit tick that falls strictly after cycle s. A tick in cycle s itself is not counted.
- R6: `ifg_done_o` stays high until the next start pulse. A start pulse clears it from the following cycle and begins a new gap.
- R7: While `en_i` is low, no tick is produced, `ifg_done_o` is low and start pulses are ignored. Re-enabling restarts every divider phase from zero.
- R8: While reset is held with the enable low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable; low clears all counters |
| presc_sel_i | input | 3 | Prescaler code (0..4 => /1../16, 5..7 => /16) |
| hbit_div_i | input | 6 | Half-bit divider, divide by value+1 |
| twin_div_i | input | 5 | Transition-window divider, divide by value+1 |
| ifg_div_i | input | 5 | Inter-frame gap length, value+1 half-bit ticks |
| ifg_start_i | input | 1 | Gap timer start/restart pulse |
| hbit_tick_o | output | 1 | Half-bit tick, one clock wide |
| twin_tick_o | output | 1 | Transition-window strobe, one clock wide |
| ifg_done_o | output | 1 | Inter-frame gap expired flag |

## Verification
The hardest case to reach is a gap start that lands in the same clock as a half-bit tick, because the free-running half-bit phase is not visible at the ports. The bench computes that phase from the number of enabled clocks since the enable rose. For one configuration it places the start exactly on a predicted tick cycle, so the coincident tick must be excluded. The bench also restarts a gap after it has expired, and it pulses start while the block is disabled to show that the pulse is ignored.

// File: rtl/pd_timing_pkg.sv
`timescale 1ns/1ps
package pd_timing_pkg;
  localparam int PSEL_W   = 3;  // prescaler code width
  localparam int PSEL_MAX = 4;  // highest valid code, 2^PSEL_MAX max ratio
  localparam int HDIV_W   = 6;
  localparam int TWIN_W   = 5;
  localparam int IFG_W    = 5;
endpackage

// File: rtl/pd_prescaler.sv
`timescale 1ns/1ps
module pd_prescaler #(
  parameter int SEL_W   = 3,
  parameter int SEL_MAX = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int CNT_W = (SEL_MAX < 1) ? 1 : SEL_MAX;

  logic [SEL_W-1:0] sel_eff;
  logic [CNT_W:0]   ratio;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_q;

  // reserved codes saturate to the largest ratio
  always_comb begin
    sel_eff = (int'(sel_i) > SEL_MAX) ? SEL_W'(SEL_MAX) : sel_i;
    ratio   = (CNT_W+1)'(1) << sel_eff;
    limit   = CNT_W'(ratio - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!en_i)          cnt_q <= '0;
    else if (cnt_q == limit) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == limit);

  AST_PCNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= limit); // R1
  AST_PCNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/pd_tick_div.sv
`timescale 1ns/1ps
module pd_tick_div #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_q == div_i) ? '0 : cnt_q + 1'b1;
  end

  assign tick_o = tick_i && (cnt_q == div_i);

  AST_DIV_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> cnt_q <= div_i); // R3
  AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/pd_gap_timer.sv
`timescale 1ns/1ps
module pd_gap_timer #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic         start_i,
  input  logic [W-1:0] len_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;
  logic         run_q;
  logic         done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; run_q <= 1'b0; done_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0; run_q <= 1'b0; done_q <= 1'b0;
    end else if (start_i) begin
      // restart wins over a coincident tick
      cnt_q <= '0; run_q <= 1'b1; done_q <= 1'b0;
    end else if (run_q && tick_i) begin
      if (cnt_q == len_i) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign done_o = done_q && en_i;

  AST_DONE_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(tick_i)); // R5
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && start_i) |=> !done_q); // R6
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && done_q && !start_i) |=> done_q); // R6
  AST_DONE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !done_q && !run_q); // R7
endmodule

// File: rtl/pd_phy_timing_gen.sv
`timescale 1ns/1ps
module pd_phy_timing_gen
  import pd_timing_pkg::*;
#(
  parameter int P_SEL_W   = PSEL_W,
  parameter int P_SEL_MAX = PSEL_MAX,
  parameter int P_HDIV_W  = HDIV_W,
  parameter int P_TWIN_W  = TWIN_W,
  parameter int P_IFG_W   = IFG_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [P_SEL_W-1:0]  presc_sel_i,
  input  logic [P_HDIV_W-1:0] hbit_div_i,
  input  logic [P_TWIN_W-1:0] twin_div_i,
  input  logic [P_IFG_W-1:0]  ifg_div_i,
  input  logic                ifg_start_i,
  output logic                hbit_tick_o,
  output logic                twin_tick_o,
  output logic                ifg_done_o
);
  logic presc_tick;

  pd_prescaler #(.SEL_W(P_SEL_W), .SEL_MAX(P_SEL_MAX)) u_presc (
    .clk_i, .rst_ni, .en_i,
    .sel_i (presc_sel_i),
    .tick_o(presc_tick)
  );

  pd_tick_div #(.W(P_HDIV_W)) u_hbit (
    .clk_i, .rst_ni, .en_i,
    .tick_i(presc_tick),
    .div_i (hbit_div_i),
    .tick_o(hbit_tick_o)
  );

  pd_tick_div #(.W(P_TWIN_W)) u_twin (
    .clk_i, .rst_ni, .en_i,
    .tick_i(hbit_tick_o),
    .div_i (twin_div_i),
    .tick_o(twin_tick_o)
  );

  pd_gap_timer #(.W(P_IFG_W)) u_ifg (
    .clk_i, .rst_ni, .en_i,
    .tick_i (hbit_tick_o),
    .start_i(ifg_start_i),
    .len_i  (ifg_div_i),
    .done_o (ifg_done_o)
  );

  AST_TWIN_WITH_HBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    twin_tick_o |-> hbit_tick_o); // R4
  AST_HBIT_NEEDS_PRESC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hbit_tick_o |-> presc_tick); // R3
endmodule

// File: tb/pd_phy_timing_gen_bench.sv
`timescale 1ns/1ps
module pd_phy_timing_gen_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en = 1'b0;
  logic [2:0] psel = '0;
  logic [5:0] hdiv = '0;
  logic [4:0] twdiv = '0;
  logic [4:0] gdiv = '0;
  logic       start = 1'b0;
  logic       hbit_tick_o, twin_tick_o, ifg_done_o;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  int q_hbit[$];
  int q_twin[$];
  int q_ifg[$];

  always #2.5 clk = ~clk;

  pd_phy_timing_gen u_pd_phy_timing_gen (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en),
    .presc_sel_i(psel), .hbit_div_i(hdiv), .twin_div_i(twdiv),
    .ifg_div_i(gdiv), .ifg_start_i(start),
    .hbit_tick_o(hbit_tick_o), .twin_tick_o(twin_tick_o),
    .ifg_done_o(ifg_done_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard compare of one event stream against expected cycle indexes
  task automatic scb(ref int q[$], input logic ev, input int cyc, input string tag);
    while (q.size() > 0 && q[0] < cyc) begin
      check(1'b0, {tag, " missed event"}, -1, q[0]);
      void'(q.pop_front());
    end
    if (ev) begin
      if (q.size() > 0 && q[0] == cyc) begin
        check(1'b1, tag, cyc, cyc);
        void'(q.pop_front());
      end else begin
        check(1'b0, {tag, " unexpected event"}, cyc, (q.size() > 0) ? q[0] : -1);
      end
    end
  endtask

  // monitor: samples 1 ns after each falling edge
  initial begin
    int  cyc = 0;
    logic prev_done = 1'b0;
    forever begin
      @(negedge clk); #1;
      if (en) begin
        scb(q_hbit, hbit_tick_o, cyc, "R3 hbit tick");
        scb(q_twin, twin_tick_o, cyc, "R4 window tick");
        scb(q_ifg, ifg_done_o && !prev_done, cyc, "R5 gap done rise");
        prev_done = ifg_done_o;
        cyc++;
      end else begin
        if (hbit_tick_o || twin_tick_o || ifg_done_o)
          check(1'b0, "R7 output while disabled",
                {29'd0, hbit_tick_o, twin_tick_o, ifg_done_o}, 0);
        cyc = 0;
        prev_done = 1'b0;
      end
    end
  end

  task automatic flush(ref int q[$], input string tag);
    while (q.size() > 0) begin
      check(1'b0, {tag, " never seen"}, -1, q[0]);
      void'(q.pop_front());
    end
  endtask

  // driver: computes expected event cycles from the requirements, then runs
  task automatic run_cfg(input int p, input int h, input int t, input int g,
                         input int n, input int s, input int s2);
    int pr, l, lw, m, d;
    pr = 1 << ((p > 4) ? 4 : p);   // R1 R2
    l  = pr * (h + 1);
    lw = l * (t + 1);
    psel = 3'(p); hdiv = 6'(h); twdiv = 5'(t); gdiv = 5'(g);
    for (int k = 1; k * l - 1 < n; k++) q_hbit.push_back(k * l - 1);
    for (int k = 1; k * lw - 1 < n; k++) q_twin.push_back(k * lw - 1);
    if (s >= 0) begin
      m = (s + 1) / l + 1;
      d = (m + g) * l;
      q_ifg.push_back(d);
    end
    if (s2 >= 0) begin
      m = (s2 + 1) / l + 1;
      d = (m + g) * l;
      q_ifg.push_back(d);
    end
    @(negedge clk);
    en = 1'b1;
    start = (s == 0);
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      start = (i == s) || (i == s2);
      if (s2 >= 0 && i == s2 + 1) begin
        #1.5;
        check(ifg_done_o == 1'b0, "R6 restart clears done", ifg_done_o, 0);
      end
    end
    #1.5;
    check(ifg_done_o == (s >= 0), "R6 done held until restart", ifg_done_o, (s >= 0));
    @(negedge clk);
    en = 1'b0;
    start = 1'b0;
    #1.5;
    check({hbit_tick_o, twin_tick_o, ifg_done_o} == 3'b000, "R7 quiet after disable",
          {hbit_tick_o, twin_tick_o, ifg_done_o}, 0);
    repeat (4) @(negedge clk);
    flush(q_hbit, "R3 hbit tick");
    flush(q_twin, "R4 window tick");
    flush(q_ifg, "R5 gap done");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check({hbit_tick_o, twin_tick_o, ifg_done_o} == 3'b000, "R8 reset outputs",
          {hbit_tick_o, twin_tick_o, ifg_done_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    run_cfg(0, 0, 0, 0, 20, 3, 10);       // R1 /1, every cycle ticks
    run_cfg(2, 3, 2, 1, 200, 15, 100);    // R5 start on a tick cycle
    run_cfg(6, 1, 1, 3, 400, 10, -1);     // R2 reserved code
    run_cfg(1, 5, 4, 2, 300, 0, -1);      // R1 /2
    run_cfg(4, 0, 3, 0, 200, 40, -1);     // R1 /16
    run_cfg(3, 2, 0, 0, 100, 5, -1);      // R1 /8
    run_cfg(7, 0, 1, 0, 100, 20, -1);     // R2 code 7
    // R7: start while disabled is ignored; no done after enabling
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    run_cfg(0, 2, 1, 0, 60, -1, -1);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule